// File: doc/BRIEF.md
# Attribute-Aware Memory Ordering Buffer

This block sits between a processor's load/store port and one system bus port and decides when each access may go out. Every request carries an address, a read/write flag, write data, a memory-type tag and a shareability bit. Writes to Normal and Device memory are posted into a small in-order buffer and acknowledged right away. Reads and Strongly-ordered writes are blocking: the processor waits for their response.

A blocking access may overtake buffered writes, but only where the ordering rules for its memory type allow it. Normal reads also forward the newest buffered data for a matching address, so they need no bus trip. An instruction fetch aimed at an execute-never region is dropped and raises a one-cycle fault pulse. The memory attributes arrive already decoded with each request.

Memory-type encoding on `req_mtype` and `bus_mtype`: 0 is Normal, 1 is Device, and 2 or 3 is Strongly-ordered. Strongly-ordered accesses always reach the bus with code 2. A Device access uses `req_share` to pick its class: 0 is the non-shareable class and 1 is the shareable class.

Top module: `mem_order_buf`

## Requirements
- R1: After reset the buffer is empty, `req_ready` is 1, and `bus_valid`, `rsp_valid` and `xn_fault` are 0.
- R2: Normal and Device writes are accepted without waiting for the bus. `req_ready` falls once four writes are held in the buffer.
- R3: A Strongly-ordered write is never posted. `req_ready` stays 0 from its acceptance until the bus completes it. `rsp_valid` pulses in the cycle after that bus handshake.
- R4: A Normal read is issued ahead of buffered writes that are still waiting for the bus.
- R5: A Device read is not issued while the buffer holds a Device write of the same shareability class. It may overtake Device writes of the other class.
- R6: A Strongly-ordered access is not issued while any Device write is buffered. Normal writes buffered before it may go out after it.
- R7: A Strongly-ordered access always appears on the bus with `bus_share` = 1, whatever `req_share` was.
- R8: A Normal read whose address matches a buffered write returns the youngest matching buffered data, one cycle after acceptance, with no bus read.
- R9: A fetch (`req_fetch` = 1) with `req_xn` = 1 starts no bus transaction. It sets `xn_fault` for exactly one cycle, in the cycle after acceptance.
- R10: While `bus_valid` is 1 and `bus_ready` is 0, the bus request holds steady. Only one bus transaction is outstanding at a time, and buffered writes leave in the order they were accepted.
- R11: A bus read's `bus_rdata` is returned on `rsp_rdata` with `rsp_valid` = 1 in the cycle after the bus handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_mtype | input | 2 | Memory type code |
| req_share | input | 1 | Shareability bit |
| req_fetch | input | 1 | Request is an instruction fetch (read) |
| req_xn | input | 1 | Target region is execute-never |
| rsp_valid | output | 1 | Response for a blocking access |
| rsp_rdata | output | 32 | Read data for the response |
| xn_fault | output | 1 | Execute-never fault pulse |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus completes the request on this edge |
| bus_addr | output | 32 | Bus address |
| bus_write | output | 1 | Bus write flag |
| bus_wdata | output | 32 | Bus write data |
| bus_mtype | output | 2 | Memory type of the bus access |
| bus_share | output | 1 | Effective shareability of the bus access |
| bus_rdata | input | 32 | Bus read data, valid with bus_ready |

## Verification
The bench stalls the bus so that writes pile up in the buffer, then issues a blocking access and records the bus order once the stall is released. A design that overtakes too freely lets a Device read or a Strongly-ordered access pass a conflicting Device write, and a design that overtakes too little holds a Normal read behind unrelated writes. Forwarding is tested with several writes to one address, so a design that returns the oldest match or the bus value shows up. A design that posts a Strongly-ordered write, fails to force shareability, or issues an execute-never fetch shows up at `req_ready`, `bus_share` or in the bus log. A random phase gives each type its own address range and checks every read against program order.

// File: rtl/mob_pkg.sv
package mob_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        MT_NORMAL     = 2'd0,
        MT_DEVICE     = 2'd1,
        MT_STRONG     = 2'd2,
        MT_STRONG_ALT = 2'd3
    } mtype_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] data;
        mtype_e            mt;
        logic              share;
    } acc_t;

    function automatic logic is_strong(mtype_e m);
        return (m == MT_STRONG) || (m == MT_STRONG_ALT);
    endfunction

    // Strongly-ordered collapses to a single code and is always shareable
    function automatic acc_t normalize(acc_t a);
        acc_t r;
        r = a;
        if (is_strong(a.mt)) begin
            r.mt    = MT_STRONG;
            r.share = 1'b1;
        end
        return r;
    endfunction

    // May a blocking access go ahead of what the buffer currently holds?
    function automatic logic may_bypass(acc_t p, logic dev_ns, logic dev_sh);
        case (p.mt)
            MT_NORMAL: return 1'b1;
            MT_DEVICE: return p.share ? !dev_sh : !dev_ns;
            default:   return !(dev_ns || dev_sh);
        endcase
    endfunction

endpackage

// File: rtl/mob_post_fifo.sv
module mob_post_fifo
    import mob_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  acc_t              push_acc,
    input  logic              pop,
    output acc_t              head,
    output logic              full,
    output logic              empty,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    output logic              dev_ns,
    output logic              dev_sh
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    acc_t             slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_acc;
                wr_ptr        <= wr_ptr + 1'b1;
            end
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = slots[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    // Scan oldest to youngest; later matches override earlier ones
    always_comb begin
        lk_hit  = 1'b0;
        lk_data = '0;
        dev_ns  = 1'b0;
        dev_sh  = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (CNT_W'(k) < count) begin
                if (slots[rd_ptr + PTR_W'(k)].addr == lk_addr) begin
                    lk_hit  = 1'b1;
                    lk_data = slots[rd_ptr + PTR_W'(k)].data;
                end
                if (slots[rd_ptr + PTR_W'(k)].mt == MT_DEVICE) begin
                    if (slots[rd_ptr + PTR_W'(k)].share) dev_sh = 1'b1;
                    else                                 dev_ns = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mob_issue_sel.sv
module mob_issue_sel
    import mob_pkg::*;
(
    input  logic bus_busy,
    input  logic pend_valid,
    input  logic pend_issued,
    input  acc_t pend,
    input  logic fifo_empty,
    input  acc_t head,
    input  logic dev_ns,
    input  logic dev_sh,
    output logic launch,
    output logic launch_pend,
    output acc_t launch_acc
);
    logic pend_ok;

    assign pend_ok     = pend_valid && !pend_issued && may_bypass(pend, dev_ns, dev_sh);
    assign launch_pend = !bus_busy && pend_ok;
    assign launch      = !bus_busy && (pend_ok || !fifo_empty);
    assign launch_acc  = pend_ok ? pend : head;

endmodule

// File: rtl/mem_order_buf.sv
module mem_order_buf
    import mob_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    input  logic        req_write,
    input  logic [31:0] req_wdata,
    input  logic [1:0]  req_mtype,
    input  logic        req_share,
    input  logic        req_fetch,
    input  logic        req_xn,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        xn_fault,
    output logic        bus_valid,
    input  logic        bus_ready,
    output logic [31:0] bus_addr,
    output logic        bus_write,
    output logic [31:0] bus_wdata,
    output logic [1:0]  bus_mtype,
    output logic        bus_share,
    input  logic [31:0] bus_rdata
);
    acc_t              in_acc, pend_q, bus_q, head, launch_acc;
    logic              pend_valid, pend_issued, bus_is_pend;
    logic              fifo_full, fifo_empty, lk_hit, dev_ns, dev_sh;
    logic [DATA_W-1:0] lk_data;
    logic              accept, xn_hit, do_post, do_fwd, do_pend;
    logic              launch, launch_pend, bus_done;

    always_comb begin
        in_acc.addr  = req_addr;
        in_acc.write = req_write && !req_fetch;
        in_acc.data  = req_wdata;
        in_acc.mt    = mtype_e'(req_mtype);
        in_acc.share = req_share;
        in_acc       = normalize(in_acc);
    end

    assign req_ready = !fifo_full && !pend_valid;
    assign accept    = req_valid && req_ready;
    assign xn_hit    = req_fetch && req_xn;
    assign do_post   = accept && !xn_hit && in_acc.write && !is_strong(in_acc.mt);
    assign do_fwd    = accept && !xn_hit && !in_acc.write && (in_acc.mt == MT_NORMAL) && lk_hit;
    assign do_pend   = accept && !xn_hit && !do_post && !do_fwd;
    assign bus_done  = bus_valid && bus_ready;

    mob_post_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (do_post),
        .push_acc (in_acc),
        .pop      (launch && !launch_pend),
        .head     (head),
        .full     (fifo_full),
        .empty    (fifo_empty),
        .lk_addr  (req_addr),
        .lk_hit   (lk_hit),
        .lk_data  (lk_data),
        .dev_ns   (dev_ns),
        .dev_sh   (dev_sh)
    );

    mob_issue_sel u_sel (
        .bus_busy    (bus_valid),
        .pend_valid  (pend_valid),
        .pend_issued (pend_issued),
        .pend        (pend_q),
        .fifo_empty  (fifo_empty),
        .head        (head),
        .dev_ns      (dev_ns),
        .dev_sh      (dev_sh),
        .launch      (launch),
        .launch_pend (launch_pend),
        .launch_acc  (launch_acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid  <= 1'b0;
            pend_issued <= 1'b0;
            pend_q      <= '0;
            bus_valid   <= 1'b0;
            bus_is_pend <= 1'b0;
            bus_q       <= '0;
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            xn_fault    <= 1'b0;
        end else begin
            xn_fault  <= accept && xn_hit;
            rsp_valid <= do_fwd || (bus_done && bus_is_pend);
            if (do_fwd)                       rsp_rdata <= lk_data;
            else if (bus_done && bus_is_pend) rsp_rdata <= bus_rdata;

            if (do_pend) begin
                pend_valid <= 1'b1;
                pend_q     <= in_acc;
            end

            if (launch) begin
                bus_valid   <= 1'b1;
                bus_q       <= launch_acc;
                bus_is_pend <= launch_pend;
                if (launch_pend) pend_issued <= 1'b1;
            end else if (bus_done) begin
                bus_valid <= 1'b0;
                if (bus_is_pend) begin
                    pend_valid  <= 1'b0;
                    pend_issued <= 1'b0;
                end
            end
        end
    end

    assign bus_addr  = bus_q.addr;
    assign bus_write = bus_q.write;
    assign bus_wdata = bus_q.data;
    assign bus_mtype = bus_q.mt;
    assign bus_share = bus_q.share;

endmodule

// File: rtl/mob_order_chk.sv
module mob_order_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [1:0]  req_mtype,
    input logic        req_fetch,
    input logic        req_xn,
    input logic        xn_fault,
    input logic        bus_valid,
    input logic        bus_ready,
    input logic [31:0] bus_addr,
    input logic        bus_write,
    input logic [31:0] bus_wdata,
    input logic [1:0]  bus_mtype,
    input logic        bus_share,
    input logic        dev_ns,
    input logic        dev_sh
);
    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
                                    && $stable(bus_write) && $stable(bus_wdata));

    // R3
    so_write_stall_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_write && !req_fetch && req_mtype[1] |=> !req_ready);

    // R9
    xn_fault_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_fetch && req_xn |=> xn_fault);

    // R6
    so_after_device_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_valid) && bus_mtype[1] |-> !dev_ns && !dev_sh);

    // R5
    dev_read_class_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_valid) && !bus_write && (bus_mtype == 2'd1)
            |-> !(bus_share ? dev_sh : dev_ns));

endmodule

bind mem_order_buf mob_order_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_mtype (req_mtype),
    .req_fetch (req_fetch),
    .req_xn    (req_xn),
    .xn_fault  (xn_fault),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .bus_write (bus_write),
    .bus_wdata (bus_wdata),
    .bus_mtype (bus_mtype),
    .bus_share (bus_share),
    .dev_ns    (dev_ns),
    .dev_sh    (dev_sh)
);

// File: tb/mem_order_buf_test.sv
module mem_order_buf_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 100000;
    localparam int LOG_N      = 512;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write, req_share, req_fetch, req_xn;
    logic [31:0] req_addr, req_wdata;
    logic [1:0]  req_mtype;
    logic        rsp_valid, xn_fault;
    logic [31:0] rsp_rdata;
    logic        bus_valid, bus_ready, bus_write, bus_share;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_mtype;

    logic        stall   = 1'b0;
    logic        rnd_on  = 1'b0;
    logic        rnd_ok  = 1'b1;
    logic [31:0] mem    [32];
    logic [31:0] shadow [32];
    logic [4:0]  log_a  [LOG_N];
    logic        log_w  [LOG_N];
    int          log_n;
    int          n_chk = 0;
    int          n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_order_buf uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_mtype(req_mtype),
        .req_share(req_share), .req_fetch(req_fetch), .req_xn(req_xn),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .xn_fault(xn_fault),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_mtype(bus_mtype),
        .bus_share(bus_share), .bus_rdata(bus_rdata)
    );

    // Bus-side memory model
    assign bus_ready = !stall && rnd_ok;
    assign bus_rdata = mem[bus_addr[4:0]];

    always @(negedge clk) rnd_ok <= rnd_on ? 1'($urandom % 2) : 1'b1;

    always @(posedge clk) begin
        if (rst) begin
            log_n <= 0;
            for (int i = 0; i < 32; i++) mem[i] <= '0;
        end else if (bus_valid && bus_ready) begin
            if (log_n < LOG_N) begin
                log_a[log_n] <= bus_addr[4:0];
                log_w[log_n] <= bus_write;
                log_n        <= log_n + 1;
            end
            if (bus_write) mem[bus_addr[4:0]] <= bus_wdata;
        end
    end

    task automatic check_eq(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [4:0] a, input logic [31:0] d,
                          input logic [1:0] mt, input logic sh, input logic fe, input logic xn,
                          output logic [31:0] rd, output logic flt);
        logic blocking;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = {27'd0, a}; req_wdata = d;
        req_mtype = mt; req_share = sh; req_fetch = fe; req_xn = xn;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        flt = xn_fault;
        rd  = '0;
        blocking = !(fe && xn) && (!wr || mt[1]);
        if (blocking) begin
            while (!rsp_valid) @(negedge clk);
            rd = rsp_rdata;
        end
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        f;
        int          b;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) shadow[i] = '0;
        req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
        req_mtype = 0; req_share = 0; req_fetch = 0; req_xn = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_eq("R1 req_ready", 32'(req_ready), 1);
        check_eq("R1 bus_valid", 32'(bus_valid), 0);
        check_eq("R1 rsp_valid", 32'(rsp_valid), 0);
        check_eq("R1 xn_fault", 32'(xn_fault), 0);

        // R2 and R10: posting until full, then drain in order
        stall = 1'b1;
        b = log_n;
        for (int k = 0; k < 5; k++) begin
            do_req(1'b1, 5'(k), 32'(100 + k), 2'd0, 1'b0, 1'b0, 1'b0, rd, f);
            shadow[k] = 32'(100 + k);
        end
        check_eq("R2 ready low when buffer full", 32'(req_ready), 0);
        stall = 1'b0;
        settle();
        check_eq("R2 ready back after drain", 32'(req_ready), 1);
        for (int k = 0; k < 5; k++) check_eq("R10 write drain order", 32'(log_a[b+k]), k);

        // R4: Normal read overtakes waiting writes
        stall = 1'b1;
        b = log_n;
        do_req(1'b1, 5'd1, 32'h11, 2'd0, 1'b0, 1'b0, 1'b0, rd, f);
        do_req(1'b1, 5'd2, 32'h22, 2'd0, 1'b0, 1'b0, 1'b0, rd, f);
        do_req(1'b1, 5'd8, 32'h88, 2'd1, 1'b0, 1'b0, 1'b0, rd, f);
        shadow[1] = 32'h11; shadow[2] = 32'h22; shadow[8] = 32'h88;
        fork
            do_req(1'b0, 5'd5, 32'd0, 2'd0, 1'b0, 1'b0, 1'b0, rd, f);
            begin repeat (8) @(negedge clk); stall = 1'b0; end
        join
        settle();
        check_eq("R4 read is second on bus", 32'(log_a[b+1]), 5);
        check_eq("R4 second access is a read", 32'(log_w[b+1]), 0);
        check_eq("R4 buffered write after read", 32'(log_a[b+2]), 2);
        check_eq("R11 read data", rd, shadow[5]);

        // R5: Device read waits for its class only
        stall = 1'b1;
        b = log_n;
        do_req(1'b1, 5'd8,  32'h81, 2'd1, 1'b0, 1'b0, 1'b0, rd, f);
        do_req(1'b1, 5'd9,  32'h91, 2'd1, 1'b0, 1'b0, 1'b0, rd, f);
        do_req(1'b1, 5'd12, 32'hC1, 2'd1, 1'b1, 1'b0, 1'b0, rd, f);
        shadow[8] = 32'h81; shadow[9] = 32'h91; shadow[12] = 32'hC1;
        fork
            do_req(1'b0, 5'd9, 32'd0, 2'd1, 1'b0, 1'b0, 1'b0, rd, f);
            begin repeat (8) @(negedge clk); stall = 1'b0; end
        join
        settle();
        check_eq("R5 same-class write before read", 32'(log_a[b+1]), 9);
        check_eq("R5 read third on bus", 32'(log_a[b+2]), 9);
        check_eq("R5 third access is a read", 32'(log_w[b+2]), 0);
        check_eq("R5 other class write after read", 32'(log_a[b+3]), 12);
        check_eq("R5 read data", rd, 32'h91);

        // R6: Strongly-ordered read waits for all Device writes
        stall = 1'b1;
        b = log_n;
        do_req(1'b1, 5'd12, 32'hC2, 2'd1, 1'b1, 1'b0, 1'b0, rd, f);
        do_req(1'b1, 5'd3,  32'h33, 2'd0, 1'b0, 1'b0, 1'b0, rd, f);
        do_req(1'b1, 5'd8,  32'h82, 2'd1, 1'b0, 1'b0, 1'b0, rd, f);
        do_req(1'b1, 5'd4,  32'h44, 2'd0, 1'b0, 1'b0, 1'b0, rd, f);
        shadow[12] = 32'hC2; shadow[3] = 32'h33; shadow[8] = 32'h82; shadow[4] = 32'h44;
        fork
            do_req(1'b0, 5'd16, 32'd0, 2'd3, 1'b0, 1'b0, 1'b0, rd, f);
            begin repeat (8) @(negedge clk); stall = 1'b0; end
        join
        settle();
        check_eq("R6 device write before strong read", 32'(log_a[b+2]), 8);
        check_eq("R6 strong read fourth", 32'(log_a[b+3]), 16);
        check_eq("R6 normal write after strong read", 32'(log_a[b+4]), 4);

        // R3 and R7: Strongly-ordered write blocks, forced shareable
        stall = 1'b1;
        fork
            do_req(1'b1, 5'd17, 32'h5A5A, 2'd2, 1'b0, 1'b0, 1'b0, rd, f);
            begin
                repeat (4) @(negedge clk);
                check_eq("R3 ready low while strong write waits", 32'(req_ready), 0);
                check_eq("R3 strong write on bus", 32'(bus_valid), 1);
                check_eq("R7 strong access shareable", 32'(bus_share), 1);
                check_eq("R3 no response before bus completes", 32'(rsp_valid), 0);
                stall = 1'b0;
            end
        join
        shadow[17] = 32'h5A5A;
        check_eq("R3 strong write reached memory", mem[17], 32'h5A5A);
        @(negedge clk);
        check_eq("R3 ready after completion", 32'(req_ready), 1);

        // R8: forwarding of youngest buffered write
        stall = 1'b1;
        b = log_n;
        do_req(1'b1, 5'd6, 32'hA0, 2'd0, 1'b0, 1'b0, 1'b0, rd, f);
        do_req(1'b1, 5'd6, 32'hB0, 2'd0, 1'b0, 1'b0, 1'b0, rd, f);
        do_req(1'b1, 5'd6, 32'hC0, 2'd0, 1'b0, 1'b0, 1'b0, rd, f);
        shadow[6] = 32'hC0;
        do_req(1'b0, 5'd6, 32'd0, 2'd0, 1'b0, 1'b0, 1'b0, rd, f);
        check_eq("R8 forwarded youngest data", rd, 32'hC0);
        stall = 1'b0;
        settle();
        check_eq("R8 no bus read for forwarded load", 32'(log_n - b), 3);

        // R9: execute-never fetch
        b = log_n;
        do_req(1'b0, 5'd2, 32'd0, 2'd0, 1'b0, 1'b1, 1'b1, rd, f);
        check_eq("R9 fault pulse", 32'(f), 1);
        @(negedge clk);
        check_eq("R9 fault lasts one cycle", 32'(xn_fault), 0);
        settle();
        check_eq("R9 no bus access for fetch", 32'(log_n - b), 0);

        // Random mix, one address range per type; reads follow program order
        rnd_on = 1'b1;
        for (int i = 0; i < 300; i++) begin
            logic [4:0]  a;
            logic [1:0]  mt;
            logic        sh, wr;
            logic [31:0] d;
            wr = 1'($urandom % 2);
            d  = $urandom;
            case ($urandom % 4)
                0: begin a = 5'($urandom % 8);       mt = 2'd0; sh = 1'($urandom % 2); end
                1: begin a = 5'(8 + $urandom % 4);   mt = 2'd1; sh = 1'b0; end
                2: begin a = 5'(12 + $urandom % 4);  mt = 2'd1; sh = 1'b1; end
                default: begin a = 5'(16 + $urandom % 4); mt = 2'(2 + $urandom % 2); sh = 1'($urandom % 2); end
            endcase
            do_req(wr, a, d, mt, sh, 1'b0, 1'b0, rd, f);
            if (wr) shadow[a] = d;
            else    check_eq("R11 random read value", rd, shadow[a]);
        end
        rnd_on = 1'b0;
        settle();
        begin
            int bad = 0;
            for (int i = 0; i < 20; i++) if (mem[i] !== shadow[i]) bad++;
            check_eq("R10 final memory matches program order", 32'(bad), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule